// File: doc/BRIEF.md
# Scan Chain with Test-Controlled Reset

This block is a row of scannable registers joined into one serial chain, with a reset selector that drives every register. Each register has an input multiplexer. When `scan_en` is high, the register takes the output of the register before it. When `scan_en` is low, it takes its own bit of the functional data vector. Holding `scan_en` high moves a test pattern in through `scan_in` and moves the old contents out through `scan_out`. Dropping `scan_en` for one clock captures the functional data into the chain.

All registers share one asynchronous, active-low reset, and the reset selector produces it. The selector chooses between the functional reset and a controllable reset. The controllable reset comes either from a pad input or from a bit of a test data register, and a static input picks which one.

A second static input sets what drives the selector:
- **Test-mode following:** the controllable reset is used whenever test mode is on.
- **Scan-enable following:** the controllable reset is used only while shifting. The functional reset then stays live during capture cycles, so its paths can be exercised, while shifted data stays protected from it.

Top module: `scan_chain_rst`

## Requirements
- R1: While `scan_en` is 1 and the applied reset is inactive, each rising clock edge loads stage 0 from `scan_in` and stage i from stage i-1 (`state_q[i]` takes the old `state_q[i-1]`).
- R2: While `scan_en` is 0 and the applied reset is inactive, each rising clock edge loads every stage i from `func_d[i]`.
- R3: `scan_out` is the last stage, `state_q[N-1]`. After N shift clocks, `scan_out` presents the shifted-in bits in the order they entered, first bit first, one per further shift clock.
- R4: When the applied reset is 0, all stages clear to 0 at once, without waiting for a clock edge, and they stay 0 while it remains 0.
- R5: With `rst_follow_se` = 0 and `test_mode` = 1, the controllable reset is applied. The functional reset has no effect in both shift and capture cycles.
- R6: With `rst_follow_se` = 1 and `scan_en` = 1, the controllable reset is applied. Driving `func_rst_n` low during shifting leaves the shifted data intact.
- R7: With `rst_follow_se` = 1 and `scan_en` = 0, the functional reset is applied. `func_rst_n` = 0 during a capture cycle clears all stages.
- R8: The controllable reset is `pad_rst_n` when `ctl_from_tdr` = 0 and `tdr_rst_n` when `ctl_from_tdr` = 1. The unselected one has no effect.
- R9: With `rst_follow_se` = 0 and `test_mode` = 0, the functional reset is applied whatever the value of `scan_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all stages |
| func_d | input | N | Functional data, one bit per stage, loaded on capture |
| scan_in | input | 1 | Serial input to stage 0 |
| scan_en | input | 1 | 1 = shift, 0 = capture |
| test_mode | input | 1 | 1 = scan operation, 0 = functional operation |
| func_rst_n | input | 1 | Functional asynchronous reset, active low |
| pad_rst_n | input | 1 | Controllable reset from a pad, active low |
| tdr_rst_n | input | 1 | Controllable reset from a test register bit, active low |
| rst_follow_se | input | 1 | Static: 0 = selector follows test_mode, 1 = selector follows scan_en |
| ctl_from_tdr | input | 1 | Static: 0 = controllable reset from pad, 1 = from test register bit |
| scan_out | output | 1 | Serial output, last stage |
| state_q | output | N | Parallel contents of all stages |

## Verification
The hardest case is a functional reset that arrives in the middle of a shift. It must be ignored while `scan_en` is high, yet the same reset must clear the chain on the next capture cycle. The stimulus first fills the chain with a known pattern, then pulses `func_rst_n` during shifting and confirms that the pattern is intact. It then asserts `func_rst_n` again in a capture cycle and expects all stages to read zero. The same sequence is replayed under test-mode following, with each source of the controllable reset, and under random mixes of all control inputs.

// File: rtl/scan_rst_pkg.sv
`timescale 1ns/1ps
package scan_rst_pkg;

    localparam int unsigned CHAIN_LEN_DEF = 8;

    // What steers the reset selector
    typedef enum logic {
        RSEL_FOLLOW_TM = 1'b0,
        RSEL_FOLLOW_SE = 1'b1
    } rsel_mode_e;

    // Where the controllable reset is taken from
    typedef enum logic {
        CTL_FROM_PAD = 1'b0,
        CTL_FROM_TDR = 1'b1
    } ctl_src_e;

    typedef struct packed {
        logic func_n;
        logic pad_n;
        logic tdr_n;
    } rst_inputs_t;

    typedef struct packed {
        rsel_mode_e mode;
        ctl_src_e   src;
        logic       test_mode;
        logic       scan_en;
    } rst_ctrl_t;

    function automatic logic pick_ctl(input ctl_src_e src, input rst_inputs_t r);
        return (src == CTL_FROM_TDR) ? r.tdr_n : r.pad_n;
    endfunction

    function automatic logic pick_select(input rst_ctrl_t c);
        return (c.mode == RSEL_FOLLOW_SE) ? c.scan_en : c.test_mode;
    endfunction

endpackage

// File: rtl/scan_rst_select.sv
`timescale 1ns/1ps
module scan_rst_select
    import scan_rst_pkg::*;
(
    input  rst_inputs_t rsts,
    input  rst_ctrl_t   ctrl,
    output logic        ctl_rst_n,
    output logic        sel_ctl,
    output logic        rst_out_n
);

    always_comb begin
        ctl_rst_n = pick_ctl(ctrl.src, rsts);
        sel_ctl   = pick_select(ctrl);
        rst_out_n = sel_ctl ? ctl_rst_n : rsts.func_n;
    end

endmodule

// File: rtl/scan_cell.sv
`timescale 1ns/1ps
module scan_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic se,
    input  logic d,
    input  logic si,
    output logic q
);

    logic nxt;

    always_comb nxt = se ? si : d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= 1'b0;
        else        q <= nxt;
    end

    // R1: a shift clock moves the serial input into the cell
    a_r1_shift_load: assert property (@(posedge clk) disable iff (!rst_n)
        se |=> (q == $past(si)));

    // R2: a capture clock loads functional data
    a_r2_capture_load: assert property (@(posedge clk) disable iff (!rst_n)
        !se |=> (q == $past(d)));

endmodule

// File: rtl/scan_chain_rst.sv
`timescale 1ns/1ps
module scan_chain_rst
    import scan_rst_pkg::*;
#(
    parameter int unsigned N = CHAIN_LEN_DEF
) (
    input  logic         clk,
    input  logic [N-1:0] func_d,
    input  logic         scan_in,
    input  logic         scan_en,
    input  logic         test_mode,
    input  logic         func_rst_n,
    input  logic         pad_rst_n,
    input  logic         tdr_rst_n,
    input  logic         rst_follow_se,
    input  logic         ctl_from_tdr,
    output logic         scan_out,
    output logic [N-1:0] state_q
);

    localparam int unsigned LAST = N - 1;

    rst_inputs_t rsts;
    rst_ctrl_t   ctrl;
    logic        ctl_rst_n;
    logic        sel_ctl;
    logic        stage_rst_n;
    logic [N:0]  link;

    always_comb begin
        rsts.func_n    = func_rst_n;
        rsts.pad_n     = pad_rst_n;
        rsts.tdr_n     = tdr_rst_n;
        ctrl.mode      = rsel_mode_e'(rst_follow_se);
        ctrl.src       = ctl_src_e'(ctl_from_tdr);
        ctrl.test_mode = test_mode;
        ctrl.scan_en   = scan_en;
    end

    scan_rst_select u_rsel (
        .rsts      (rsts),
        .ctrl      (ctrl),
        .ctl_rst_n (ctl_rst_n),
        .sel_ctl   (sel_ctl),
        .rst_out_n (stage_rst_n)
    );

    assign link[0] = scan_in;

    for (genvar i = 0; i < N; i++) begin : g_stage
        scan_cell u_cell (
            .clk   (clk),
            .rst_n (stage_rst_n),
            .se    (scan_en),
            .d     (func_d[i]),
            .si    (link[i]),
            .q     (link[i+1])
        );
        assign state_q[i] = link[i+1];
    end

    assign scan_out = state_q[LAST];

    // R4: an applied reset leaves every stage cleared
    a_r4_clear_all: assert property (@(posedge clk)
        !stage_rst_n |-> (state_q == '0));

    // R6: while shifting under scan-enable following, the functional reset is shut out
    a_r6_shift_protect: assert property (@(posedge clk)
        (rst_follow_se && scan_en) |-> (stage_rst_n == ctl_rst_n));

    // R7: capture under scan-enable following passes the functional reset
    a_r7_capture_live: assert property (@(posedge clk)
        (rst_follow_se && !scan_en) |-> (stage_rst_n == func_rst_n));

    // R5: test mode under test-mode following never uses the functional reset
    a_r5_tm_controlled: assert property (@(posedge clk)
        (!rst_follow_se && test_mode) |-> (stage_rst_n == (ctl_from_tdr ? tdr_rst_n : pad_rst_n)));

    // R9: functional operation under test-mode following uses the functional reset
    a_r9_func_path: assert property (@(posedge clk)
        (!rst_follow_se && !test_mode) |-> (stage_rst_n == func_rst_n));

endmodule

// File: tb/tb_scan_chain_rst.sv
`timescale 1ns/1ps
module tb_scan_chain_rst;

    localparam int unsigned N = 8;

    logic         clk = 1'b0;
    logic [N-1:0] func_d = '0;
    logic         scan_in = 1'b0;
    logic         scan_en = 1'b0;
    logic         test_mode = 1'b1;
    logic         func_rst_n = 1'b0;
    logic         pad_rst_n = 1'b1;
    logic         tdr_rst_n = 1'b1;
    logic         rst_follow_se = 1'b1;
    logic         ctl_from_tdr = 1'b0;
    logic         scan_out;
    logic [N-1:0] state_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [N-1:0] model = '0;

    always #4 clk = ~clk;

    scan_chain_rst #(.N(N)) dut (
        .clk           (clk),
        .func_d        (func_d),
        .scan_in       (scan_in),
        .scan_en       (scan_en),
        .test_mode     (test_mode),
        .func_rst_n    (func_rst_n),
        .pad_rst_n     (pad_rst_n),
        .tdr_rst_n     (tdr_rst_n),
        .rst_follow_se (rst_follow_se),
        .ctl_from_tdr  (ctl_from_tdr),
        .scan_out      (scan_out),
        .state_q       (state_q)
    );

    function automatic logic applied_rst_n();
        logic sel;
        logic ctl;
        sel = rst_follow_se ? scan_en : test_mode;
        ctl = ctl_from_tdr ? tdr_rst_n : pad_rst_n;
        return sel ? ctl : func_rst_n;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One clock: inputs driven after the falling edge, result compared at the next falling edge
    task automatic cyc(input logic se, input logic [N-1:0] d, input logic si, input string req);
        logic eff;
        scan_en = se;
        func_d  = d;
        scan_in = si;
        #1;
        eff = applied_rst_n();
        if (!eff) model = '0;
        @(posedge clk);
        if (eff) model = se ? {model[N-2:0], si} : d;
        @(negedge clk);
        check(state_q == model, req, 64'(state_q), 64'(model));
        check(scan_out == model[N-1], {req, " scan_out"}, 64'(scan_out), 64'(model[N-1]));
    endtask

    task automatic set_rst(input logic f, input logic p, input logic t);
        func_rst_n = f;
        pad_rst_n  = p;
        tdr_rst_n  = t;
    endtask

    initial begin
        #1_600_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [N-1:0] pat;
        void'($urandom(32'h5CA1_0042));
        @(negedge clk);

        // R4: functional reset applied in capture under scan-enable following
        set_rst(1'b0, 1'b1, 1'b1);
        cyc(1'b0, '1, 1'b1, "R4 reset state");
        check(state_q == '0, "R4 cleared", 64'(state_q), 64'h0);
        set_rst(1'b1, 1'b1, 1'b1);

        // R1, R6: shift a pattern while pulsing the functional reset
        pat = N'($urandom());
        for (int k = 0; k < N; k++) begin
            func_rst_n = (k % 3 == 1) ? 1'b0 : 1'b1;
            cyc(1'b1, N'($urandom()), pat[k], "R6 shift under functional reset");
        end
        func_rst_n = 1'b1;
        check(state_q == {<<{pat}}, "R1 pattern loaded", 64'(state_q), 64'({<<{pat}}));

        // R3: serial order at scan_out, first bit first
        for (int k = 0; k < N; k++) begin
            check(scan_out == pat[k], "R3 serial order", 64'(scan_out), 64'(pat[k]));
            cyc(1'b1, '0, 1'b0, "R1 shift out");
        end

        // R2: capture several distinct vectors
        cyc(1'b0, 8'hA5, 1'b0, "R2 capture A5");
        cyc(1'b0, 8'h3C, 1'b1, "R2 capture 3C");
        cyc(1'b0, 8'h81, 1'b0, "R2 capture 81");

        // R7: functional reset during capture clears
        func_rst_n = 1'b0;
        cyc(1'b0, 8'hFF, 1'b0, "R7 capture reset");
        check(state_q == '0, "R7 cleared", 64'(state_q), 64'h0);
        func_rst_n = 1'b1;

        // R8: pad is the controllable source, the test register bit is ignored
        for (int k = 0; k < N; k++) cyc(1'b1, '0, 1'b1, "R1 fill");
        ctl_from_tdr = 1'b0;
        set_rst(1'b1, 1'b1, 1'b0);
        cyc(1'b1, '0, 1'b1, "R8 tdr ignored when pad chosen");
        check(state_q == '1, "R8 tdr ignored", 64'(state_q), 64'hFF);
        set_rst(1'b1, 1'b0, 1'b1);
        cyc(1'b1, '0, 1'b1, "R8 pad reset applied");
        set_rst(1'b1, 1'b1, 1'b1);
        for (int k = 0; k < N; k++) cyc(1'b1, '0, 1'b1, "R1 fill");
        ctl_from_tdr = 1'b1;
        set_rst(1'b1, 1'b0, 1'b1);
        cyc(1'b1, '0, 1'b1, "R8 pad ignored when tdr chosen");
        check(state_q == '1, "R8 pad ignored", 64'(state_q), 64'hFF);
        set_rst(1'b1, 1'b1, 1'b0);
        cyc(1'b1, '0, 1'b1, "R8 tdr reset applied");
        set_rst(1'b1, 1'b1, 1'b1);
        ctl_from_tdr = 1'b0;

        // R5: test-mode following, functional reset has no effect in test mode
        rst_follow_se = 1'b0;
        test_mode = 1'b1;
        cyc(1'b0, 8'h5A, 1'b0, "R2 capture 5A");
        func_rst_n = 1'b0;
        cyc(1'b0, 8'hC3, 1'b0, "R5 capture ignores functional reset");
        check(state_q == 8'hC3, "R5 captured", 64'(state_q), 64'hC3);
        cyc(1'b1, '0, 1'b1, "R5 shift ignores functional reset");
        func_rst_n = 1'b1;

        // R9: functional operation uses the functional reset even while shifting
        test_mode = 1'b0;
        cyc(1'b1, '0, 1'b1, "R1 shift functional mode");
        func_rst_n = 1'b0;
        cyc(1'b1, '0, 1'b1, "R9 functional reset while shifting");
        check(state_q == '0, "R9 cleared", 64'(state_q), 64'h0);
        func_rst_n = 1'b1;

        // Random mix of all controls, resets inactive most of the time
        for (int n = 0; n < 400; n++) begin
            logic se;
            rst_follow_se = 1'($urandom());
            ctl_from_tdr  = 1'($urandom());
            test_mode     = 1'($urandom());
            func_rst_n    = ($urandom_range(0, 7) != 0);
            pad_rst_n     = ($urandom_range(0, 7) != 0);
            tdr_rst_n     = ($urandom_range(0, 7) != 0);
            se = 1'($urandom());
            cyc(se, N'($urandom()), 1'($urandom()),
                !applied_rst_n() ? "R4 random reset" : (se ? "R1 random shift" : "R2 random capture"));
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule